// File: doc/BRIEF.md
# Digital Frequency-Locked Loop Controller

This block is the digital half of a frequency-locked loop. It runs on the feedback clock, which is the output of a digitally controlled oscillator. It picks one of three slow reference clocks and synchronises that reference into its own domain. It then divides the reference by a programmable ratio and counts the oscillator cycles in each divided reference period.

Each measured count is compared with a target. The target is the programmed multiplier times the post-divide factor. After each comparison the block moves a combined {tap, modulation} word one step up or down, which pulls the oscillator towards lock. The 5-bit tap picks one of 32 coarse frequency steps of roughly 8% each. The modulation field dithers between neighbouring taps. A separate post-divider gives a strobe once every 1 to 32 oscillator cycles. A limit flag shows when the tap is stuck at either end of its range.

Top module: `fll_ctl`

## Requirements
- R1: On reset the tap is 16 (mid-range), the modulation field is 0 and the limit flag is 0.
- R2: ref_sel chooses the reference. Code 000 selects ref_xtal_lo, code 101 selects ref_xtal_hi, and every other code (010 included) selects ref_int. Edges on a reference that is not selected have no effect on tap or mod.
- R3: ref_div_code sets how many reference rising edges make one measurement period. The codes are 000=1, 001=2, 010=4, 011=8, 100=12 and 101=16. The reserved codes 110 and 111 divide by 16.
- R4: post_div_code sets D. The codes are 000=1, 001=2, 010=4, 011=8, 100=16 and 101=32, and the reserved codes 110 and 111 give 32. osc_div_stb is high for one cycle in every D cycles, and it is always high when D=1.
- R5: The target count is max(mult,1) × D, so a multiplier of zero behaves exactly like a multiplier of one.
- R6: A period is the number of clk cycles between consecutive divided reference ticks. For each period, a count below target increments the word {tap, mod}, with tap as the upper 5 bits and mod as the lower 5 bits. A count above target decrements the word. An equal count leaves it unchanged.
- R7: The {tap, mod} word saturates at all-zeros and at all-ones.
- R8: When mod_dis is 1, mod holds its value and each step moves tap by exactly one, saturating at 0 and 31.
- R9: limit is 1 exactly when tap is 0 or 31.
- R10: While loop_en is 0, tap and mod hold and the period counters are cleared. The first divided tick after loop_en rises only starts a period and causes no update.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Feedback clock from the oscillator; all logic runs on it |
| rst_n | input | 1 | Active-low synchronous reset |
| loop_en | input | 1 | Enables measurement and tap/mod steering |
| mod_dis | input | 1 | Freezes the modulation field; steps then move the tap only |
| ref_sel | input | 3 | Reference source select |
| ref_div_code | input | 3 | Reference divide ratio code |
| post_div_code | input | 3 | Oscillator post-divide code |
| mult | input | 10 | Loop multiplier (0 treated as 1) |
| ref_xtal_lo | input | 1 | Low-frequency crystal reference |
| ref_int | input | 1 | Internal reference |
| ref_xtal_hi | input | 1 | High-frequency crystal reference |
| tap | output | 5 | Coarse oscillator frequency tap |
| mod | output | 5 | Modulation field |
| limit | output | 1 | Tap sits at 0 or 31 |
| osc_div_stb | output | 1 | One-cycle strobe every D feedback cycles |

## Verification
The assertions assume that the selected reference is much slower than clk. Each high and low phase of the reference must last at least two clk cycles, so that every synchronised rising edge yields a single-cycle tick. They also assume that the control codes are not changed in the middle of a period whose result matters.

The stimulus keeps to these limits. It drives reference phases of three or more cycles. It changes codes, the multiplier and mod_dis only while loop_en is low. Between runs it drops loop_en, so that the idle gap is never measured as a period.

// File: rtl/fll_ctl_pkg.sv
package fll_ctl_pkg;

   typedef enum logic [1:0] {
      STEP_HOLD = 2'd0,
      STEP_UP   = 2'd1,
      STEP_DOWN = 2'd2
   } step_e;

   // Number of reference edges per measurement period; reserved codes give 16.
   function automatic logic [4:0] ref_div_ratio(input logic [2:0] code);
      case (code)
         3'd0:    return 5'd1;
         3'd1:    return 5'd2;
         3'd2:    return 5'd4;
         3'd3:    return 5'd8;
         3'd4:    return 5'd12;
         default: return 5'd16;
      endcase
   endfunction

   // Post-divide expressed as a shift; reserved codes clamp to 32.
   function automatic logic [2:0] post_div_shift(input logic [2:0] code);
      return (code > 3'd5) ? 3'd5 : code;
   endfunction

endpackage

// File: rtl/fll_ref_front.sv
module fll_ref_front
   import fll_ctl_pkg::*;
#(
   parameter int SYNC_STAGES = 2
) (
   input  logic       clk,
   input  logic       rst_n,
   input  logic       loop_en,
   input  logic [2:0] ref_sel,
   input  logic [2:0] ref_div_code,
   input  logic       ref_xtal_lo,
   input  logic       ref_int,
   input  logic       ref_xtal_hi,
   output logic       per_tick
);

   logic                   ref_mux;
   logic [SYNC_STAGES-1:0] sync_q;
   logic                   edge_prev;
   logic                   ref_edge;
   logic [4:0]             rdiv_cnt;
   logic [4:0]             ratio;

   always_comb begin
      case (ref_sel)
         3'b000:  ref_mux = ref_xtal_lo;
         3'b101:  ref_mux = ref_xtal_hi;
         default: ref_mux = ref_int;
      endcase
   end

   assign ratio    = ref_div_ratio(ref_div_code);
   assign ref_edge = sync_q[SYNC_STAGES-1] & ~edge_prev;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         sync_q    <= '0;
         edge_prev <= 1'b0;
      end else begin
         sync_q    <= {sync_q[SYNC_STAGES-2:0], ref_mux};
         edge_prev <= sync_q[SYNC_STAGES-1];
      end
   end

   always_ff @(posedge clk) begin
      if (!rst_n || !loop_en) begin
         rdiv_cnt <= '0;
         per_tick <= 1'b0;
      end else if (ref_edge) begin
         if (rdiv_cnt >= ratio - 5'd1) begin
            rdiv_cnt <= '0;
            per_tick <= 1'b1;
         end else begin
            rdiv_cnt <= rdiv_cnt + 5'd1;
            per_tick <= 1'b0;
         end
      end else begin
         per_tick <= 1'b0;
      end
   end

   // R3: a divided tick is a single-cycle pulse
   p_tick_pulse_r3: assert property (@(posedge clk) disable iff (!rst_n)
      per_tick |=> !per_tick);

   // R10: no tick while the loop is disabled
   p_no_tick_off_r10: assert property (@(posedge clk) disable iff (!rst_n)
      !loop_en |=> !per_tick);

endmodule

// File: rtl/fll_period_meter.sv
module fll_period_meter
   import fll_ctl_pkg::*;
#(
   parameter int MULT_W = 10,
   parameter int CNT_W  = 16
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              loop_en,
   input  logic              per_tick,
   input  logic [MULT_W-1:0] mult,
   input  logic [2:0]        post_div_code,
   output step_e             step,
   output logic              step_vld
);

   logic [CNT_W-1:0] cyc_cnt;
   logic [CNT_W-1:0] n_eff;
   logic [CNT_W-1:0] target;
   logic             primed;

   assign n_eff  = (mult == '0) ? CNT_W'(1) : CNT_W'(mult);
   assign target = n_eff << post_div_shift(post_div_code);

   always_ff @(posedge clk) begin
      if (!rst_n || !loop_en) begin
         cyc_cnt  <= '0;
         primed   <= 1'b0;
         step_vld <= 1'b0;
         step     <= STEP_HOLD;
      end else if (per_tick) begin
         cyc_cnt  <= CNT_W'(1);
         primed   <= 1'b1;
         step_vld <= primed;
         if (cyc_cnt < target)      step <= STEP_UP;
         else if (cyc_cnt > target) step <= STEP_DOWN;
         else                       step <= STEP_HOLD;
      end else begin
         step_vld <= 1'b0;
         if (cyc_cnt != '1) cyc_cnt <= cyc_cnt + CNT_W'(1);
      end
   end

   // R6: a decision follows a divided tick
   p_step_after_tick_r6: assert property (@(posedge clk) disable iff (!rst_n)
      step_vld |-> $past(per_tick));

   // R10: the first tick after enable only primes
   p_prime_first_r10: assert property (@(posedge clk) disable iff (!rst_n)
      (per_tick && !primed) |=> !step_vld);

endmodule

// File: rtl/fll_tap_ctrl.sv
module fll_tap_ctrl
   import fll_ctl_pkg::*;
#(
   parameter int TAP_W = 5,
   parameter int MOD_W = 5
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             loop_en,
   input  logic             mod_dis,
   input  step_e            step,
   input  logic             step_vld,
   output logic [TAP_W-1:0] tap,
   output logic [MOD_W-1:0] mod,
   output logic             limit
);

   localparam int PW = TAP_W + MOD_W;
   localparam logic [PW-1:0] PAIR_RST = {1'b1, {(PW-1){1'b0}}};

   logic [PW-1:0] pair_q, pair_d;
   logic [PW:0]   pair_ext;

   assign tap      = pair_q[PW-1 -: TAP_W];
   assign mod      = pair_q[MOD_W-1:0];
   assign limit    = (tap == '0) || (tap == '1);
   assign pair_ext = {1'b0, pair_q};

   always_comb begin
      pair_d = pair_q;
      if (loop_en && step_vld) begin
         case (step)
            STEP_UP: begin
               if (mod_dis) begin
                  if (tap != '1) pair_d = {tap + TAP_W'(1), mod};
               end else if (pair_q != '1) begin
                  pair_d = pair_q + PW'(1);
               end
            end
            STEP_DOWN: begin
               if (mod_dis) begin
                  if (tap != '0) pair_d = {tap - TAP_W'(1), mod};
               end else if (pair_q != '0) begin
                  pair_d = pair_q - PW'(1);
               end
            end
            default: pair_d = pair_q;
         endcase
      end
   end

   always_ff @(posedge clk) begin
      if (!rst_n) pair_q <= PAIR_RST;
      else        pair_q <= pair_d;
   end

   // R6: with modulation active the word moves by at most one LSB
   p_step_one_r6: assert property (@(posedge clk) disable iff (!rst_n)
      !mod_dis |=> (pair_ext == $past(pair_ext) ||
                    pair_ext == $past(pair_ext) + 1'b1 ||
                    pair_ext == $past(pair_ext) - 1'b1));

   // R7: saturation at the top
   p_sat_hi_r7: assert property (@(posedge clk) disable iff (!rst_n)
      (pair_q == '1 && loop_en && step_vld && step == STEP_UP) |=> pair_q == '1);

   // R7: saturation at the bottom
   p_sat_lo_r7: assert property (@(posedge clk) disable iff (!rst_n)
      (pair_q == '0 && loop_en && step_vld && step == STEP_DOWN) |=> pair_q == '0);

   // R8: modulation frozen while disabled
   p_mod_freeze_r8: assert property (@(posedge clk) disable iff (!rst_n)
      mod_dis |=> $stable(mod));

   // R9: the flag only rises when the tap moves
   p_limit_rise_r9: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(limit) |-> !$stable(tap));

   // R10: the word holds while the loop is off
   p_hold_off_r10: assert property (@(posedge clk) disable iff (!rst_n)
      !loop_en |=> $stable(pair_q));

endmodule

// File: rtl/fll_post_div.sv
module fll_post_div
   import fll_ctl_pkg::*;
(
   input  logic       clk,
   input  logic       rst_n,
   input  logic [2:0] post_div_code,
   output logic       stb
);

   logic [5:0] cnt_q;
   logic [5:0] lim;

   assign lim = (6'd1 << post_div_shift(post_div_code)) - 6'd1;
   assign stb = (cnt_q >= lim);

   always_ff @(posedge clk) begin
      if (!rst_n)   cnt_q <= '0;
      else if (stb) cnt_q <= '0;
      else          cnt_q <= cnt_q + 6'd1;
   end

   // R4: divide-by-one strobes every cycle
   p_stb_div1_r4: assert property (@(posedge clk) disable iff (!rst_n)
      (post_div_code == 3'd0) |-> stb);

   // R4: after a strobe the count restarts
   p_stb_restart_r4: assert property (@(posedge clk) disable iff (!rst_n)
      (stb && post_div_code != 3'd0) |=> (cnt_q == 6'd0));

endmodule

// File: rtl/fll_ctl.sv
module fll_ctl
   import fll_ctl_pkg::*;
#(
   parameter int TAP_W       = 5,
   parameter int MOD_W       = 5,
   parameter int MULT_W      = 10,
   parameter int SYNC_STAGES = 2
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              loop_en,
   input  logic              mod_dis,
   input  logic [2:0]        ref_sel,
   input  logic [2:0]        ref_div_code,
   input  logic [2:0]        post_div_code,
   input  logic [MULT_W-1:0] mult,
   input  logic              ref_xtal_lo,
   input  logic              ref_int,
   input  logic              ref_xtal_hi,
   output logic [TAP_W-1:0]  tap,
   output logic [MOD_W-1:0]  mod,
   output logic              limit,
   output logic              osc_div_stb
);

   localparam int CNT_W = MULT_W + 6;

   if (TAP_W < 2) begin : g_chk_tap
      $error("TAP_W must be at least 2");
   end
   if (MOD_W < 1) begin : g_chk_mod
      $error("MOD_W must be at least 1");
   end
   if (MULT_W < 1) begin : g_chk_mult
      $error("MULT_W must be at least 1");
   end
   if (SYNC_STAGES < 2) begin : g_chk_sync
      $error("SYNC_STAGES must be at least 2");
   end

   logic  per_tick;
   step_e step;
   logic  step_vld;

   fll_ref_front #(.SYNC_STAGES(SYNC_STAGES)) u_front (
      .clk          (clk),
      .rst_n        (rst_n),
      .loop_en      (loop_en),
      .ref_sel      (ref_sel),
      .ref_div_code (ref_div_code),
      .ref_xtal_lo  (ref_xtal_lo),
      .ref_int      (ref_int),
      .ref_xtal_hi  (ref_xtal_hi),
      .per_tick     (per_tick)
   );

   fll_period_meter #(.MULT_W(MULT_W), .CNT_W(CNT_W)) u_meter (
      .clk           (clk),
      .rst_n         (rst_n),
      .loop_en       (loop_en),
      .per_tick      (per_tick),
      .mult          (mult),
      .post_div_code (post_div_code),
      .step          (step),
      .step_vld      (step_vld)
   );

   fll_tap_ctrl #(.TAP_W(TAP_W), .MOD_W(MOD_W)) u_tap (
      .clk      (clk),
      .rst_n    (rst_n),
      .loop_en  (loop_en),
      .mod_dis  (mod_dis),
      .step     (step),
      .step_vld (step_vld),
      .tap      (tap),
      .mod      (mod),
      .limit    (limit)
   );

   fll_post_div u_pdiv (
      .clk           (clk),
      .rst_n         (rst_n),
      .post_div_code (post_div_code),
      .stb           (osc_div_stb)
   );

endmodule

// File: tb/fll_ctl_tb.sv
module fll_ctl_tb;

   logic       clk = 1'b0;
   logic       rst_n;
   logic       loop_en, mod_dis;
   logic [2:0] ref_sel, ref_div_code, post_div_code;
   logic [9:0] mult;
   logic       ref_xtal_lo, ref_int, ref_xtal_hi;
   logic [4:0] tap, mod;
   logic       limit, osc_div_stb;

   int  n_chk = 0;
   int  n_fail = 0;
   int  exp_pair;
   bit  finished = 0;

   always #4 clk = ~clk;

   fll_ctl u_dut (
      .clk(clk), .rst_n(rst_n), .loop_en(loop_en), .mod_dis(mod_dis),
      .ref_sel(ref_sel), .ref_div_code(ref_div_code),
      .post_div_code(post_div_code), .mult(mult),
      .ref_xtal_lo(ref_xtal_lo), .ref_int(ref_int), .ref_xtal_hi(ref_xtal_hi),
      .tap(tap), .mod(mod), .limit(limit), .osc_div_stb(osc_div_stb)
   );

   task automatic chk(input string req, input int act, input int expv);
      n_chk++;
      if (act != expv) begin
         n_fail++;
         $display("FAIL %s: actual %0d expected %0d", req, act, expv);
      end
   endtask

   task automatic chk_pair(input string req);
      chk({req, " tap"}, int'(tap), exp_pair >> 5);
      chk({req, " mod"}, int'(mod), exp_pair & 31);
   endtask

   task automatic do_reset();
      @(negedge clk);
      rst_n = 0; loop_en = 0; mod_dis = 0;
      ref_sel = 3'b010; ref_div_code = 0; post_div_code = 0; mult = 0;
      ref_xtal_lo = 0; ref_int = 0; ref_xtal_hi = 0;
      repeat (4) @(negedge clk);
      rst_n = 1;
      repeat (2) @(negedge clk);
      exp_pair = 512;
   endtask

   task automatic set_line(input int line, input logic v);
      case (line)
         0: ref_xtal_lo = v;
         1: ref_int = v;
         default: ref_xtal_hi = v;
      endcase
   endtask

   // Enable (optionally), drive n reference periods of per cycles, settle, disable.
   task automatic drive_ref(input int line, input int n, input int per, input bit en);
      @(negedge clk);
      loop_en = en;
      repeat (3) @(negedge clk);
      for (int i = 0; i < n; i++) begin
         set_line(line, 1'b1);
         repeat (per / 2) @(negedge clk);
         set_line(line, 1'b0);
         repeat (per - per / 2) @(negedge clk);
      end
      repeat (30) @(negedge clk);
      loop_en = 0;
      @(negedge clk);
   endtask

   task automatic t_reset();
      do_reset();
      chk("R1 tap", int'(tap), 16);
      chk("R1 mod", int'(mod), 0);
      chk("R1 limit", int'(limit), 0);
   endtask

   task automatic t_direction();
      do_reset();
      mult = 10; drive_ref(1, 5, 20, 1); exp_pair -= 4; chk_pair("R6 too fast");
      mult = 40; drive_ref(1, 5, 20, 1); exp_pair += 4; chk_pair("R6 too slow");
      mult = 20; drive_ref(1, 5, 20, 1);                chk_pair("R6 equal");
   endtask

   task automatic t_zero_mult();
      do_reset();
      mult = 0; post_div_code = 3'd5;
      drive_ref(1, 5, 32, 1);                chk_pair("R5 zero mult equal");
      drive_ref(1, 5, 34, 1); exp_pair -= 4; chk_pair("R5 zero mult above");
   endtask

   task automatic t_post_div();
      do_reset();
      mult = 5; post_div_code = 3'd3;
      drive_ref(1, 5, 20, 1); exp_pair += 4; chk_pair("R4 div8 target");
      mult = 1; post_div_code = 3'd6;
      drive_ref(1, 5, 30, 1); exp_pair += 4; chk_pair("R4 reserved below");
      drive_ref(1, 5, 34, 1); exp_pair -= 4; chk_pair("R4 reserved above");
   endtask

   task automatic t_ref_div();
      do_reset();
      ref_div_code = 3'd4; mult = 80;
      drive_ref(1, 36, 6, 1); exp_pair += 2; chk_pair("R3 div12");
      ref_div_code = 3'd7; mult = 95;
      drive_ref(1, 32, 6, 1); exp_pair -= 1; chk_pair("R3 reserved div16");
      ref_div_code = 3'd3; mult = 47;
      drive_ref(1, 24, 6, 1); exp_pair -= 2; chk_pair("R3 div8");
   endtask

   task automatic t_ref_sel();
      do_reset();
      mult = 40;
      ref_sel = 3'b000; drive_ref(0, 5, 20, 1); exp_pair += 4; chk_pair("R2 sel 000");
      ref_sel = 3'b010; drive_ref(1, 5, 20, 1); exp_pair += 4; chk_pair("R2 sel 010");
      ref_sel = 3'b101; drive_ref(2, 5, 20, 1); exp_pair += 4; chk_pair("R2 sel 101");
      ref_sel = 3'b011; drive_ref(1, 5, 20, 1); exp_pair += 4; chk_pair("R2 sel other");
      ref_sel = 3'b010; drive_ref(0, 5, 20, 1);                chk_pair("R2 unselected lo");
      ref_sel = 3'b101; drive_ref(1, 5, 20, 1);                chk_pair("R2 unselected int");
   endtask

   task automatic t_mod_dis();
      do_reset();
      mod_dis = 1; mult = 10;
      drive_ref(1, 5, 20, 1); exp_pair = 384; chk_pair("R8 tap only down");
      mod_dis = 0;
      drive_ref(1, 2, 20, 1); exp_pair = 383; chk_pair("R8 released");
      mod_dis = 1; mult = 40;
      drive_ref(1, 3, 20, 1); exp_pair = 447; chk_pair("R8 tap only up");
   endtask

   task automatic t_saturation();
      do_reset();
      mod_dis = 1; mult = 40;
      drive_ref(1, 15, 20, 1); exp_pair = 30 * 32; chk_pair("R8 tap 30");
      chk("R9 limit at 30", int'(limit), 0);
      drive_ref(1, 7, 20, 1); exp_pair = 31 * 32; chk_pair("R8 tap sat 31");
      chk("R9 limit at 31", int'(limit), 1);
      mod_dis = 0;
      drive_ref(1, 41, 20, 1); exp_pair = 1023; chk_pair("R7 sat high");
      mod_dis = 1; mult = 10;
      drive_ref(1, 41, 20, 1); exp_pair = 31; chk_pair("R8 tap sat 0");
      chk("R9 limit at 0", int'(limit), 1);
      mod_dis = 0;
      drive_ref(1, 41, 20, 1); exp_pair = 0; chk_pair("R7 sat low");
   endtask

   task automatic t_disable();
      do_reset();
      mult = 10;
      drive_ref(1, 10, 20, 0);                chk_pair("R10 disabled hold");
      drive_ref(1, 1, 20, 1);                 chk_pair("R10 first tick primes");
      drive_ref(1, 2, 20, 1); exp_pair -= 1;  chk_pair("R10 second tick updates");
   endtask

   task automatic count_stb(input logic [2:0] code, input int expv, input string req);
      int cnt = 0;
      post_div_code = code;
      repeat (40) @(negedge clk);
      for (int i = 0; i < 64; i++) begin
         if (osc_div_stb) cnt++;
         @(negedge clk);
      end
      chk(req, cnt, expv);
   endtask

   task automatic t_strobe();
      do_reset();
      count_stb(3'd2, 16, "R4 strobe div4");
      count_stb(3'd0, 64, "R4 strobe div1");
      count_stb(3'd7, 2,  "R4 strobe reserved div32");
      count_stb(3'd4, 4,  "R4 strobe div16");
   endtask

   initial begin
      rst_n = 0; loop_en = 0; mod_dis = 0;
      ref_sel = 3'b010; ref_div_code = 0; post_div_code = 0; mult = 0;
      ref_xtal_lo = 0; ref_int = 0; ref_xtal_hi = 0;
      t_reset();
      t_direction();
      t_zero_mult();
      t_post_div();
      t_ref_div();
      t_ref_sel();
      t_mod_dis();
      t_saturation();
      t_disable();
      t_strobe();
      finished = 1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_fail);
      $finish;
   end

   initial begin
      repeat (150000) @(posedge clk);
      if (!finished) begin
         n_chk++;
         n_fail++;
         $display("FAIL watchdog: actual hung expected done");
         $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_fail);
         $finish;
      end
   end

endmodule